// File: doc/BRIEF.md
# Supervisor domain interrupt router

This block steers interrupts on a hart whose machine-mode software switches it between several isolated supervisor domains. Each domain owns a private interrupt file, and each file drives its own external interrupt line into the block. The block gathers these lines into a read-only pending word. A writable enable word holds one mask bit per domain. A domain register, written by machine mode, names the domain the hart is running.

The block drives the supervisor external interrupt from the line and enable bit of the current domain only. A machine-level summary interrupt rises whenever any domain has an unmasked line pending, so the scheduler can switch to a domain that needs service. A second pending/enable pair does the same for per-domain software interrupts.

Indirect interrupt-file CSR accesses from the hart (select, data and top-interrupt claim) are routed as an access strobe to the current domain's file only. Read data comes back from that same file.

Top module: `sd_irq_router`

## Requirements
- R1: The external pending word (CSR address 0) always reads as the current external lines, bit i for domain i. Writes to address 0 change no state.
- R2: The external enable word (CSR address 1) resets to zero and is loaded from csrWrData when csrWrEn is high. When csrRdEn is high, csrRdData takes, at that clock edge, the word selected by csrAddr as it stood before the edge. Otherwise csrRdData holds its value. csrRdData resets to zero.
- R3: The domain register resets to 0 and is loaded from domIdWrData when domIdWrEn is high. The new domain steers all outputs from the cycle after the write; during the write cycle the old domain still applies.
- R4: sExtIrq equals the external line of the current domain ANDed with that domain's external enable bit.
- R5: mExtIrq is high exactly when some domain has both its external line and its external enable bit set.
- R6: The software pair behaves in the same way as the external pair. Address 2 reads the software lines and ignores writes. Address 3 is the software enable word. sSwIrq follows the current domain, and mSwIrq is the OR over all domains.
- R7: When ifAccEn is high, ifStrobe has exactly the bit of the current domain set; otherwise it is zero. ifKindOut, ifWrOut and ifWDataOut copy ifAccKind, ifAccWr and ifAccWData to every file.
- R8: A top-interrupt claim access (ifAccKind = 2; 0 is select, 1 is data) strobes only the current domain's file. ifRData is slice d of ifRDataVec (bits d*IF_DW upward) for current domain d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extLines | input | NUM_DOM | Per-domain external interrupt lines from the interrupt files |
| swLines | input | NUM_DOM | Per-domain software interrupt lines |
| domIdWrEn | input | 1 | Load the current-domain register |
| domIdWrData | input | ID_W | New current-domain identifier |
| csrWrEn | input | 1 | CSR write strobe |
| csrRdEn | input | 1 | CSR read strobe |
| csrAddr | input | 2 | CSR select: 0 ext pending, 1 ext enable, 2 sw pending, 3 sw enable |
| csrWrData | input | NUM_DOM | CSR write data |
| csrRdData | output | NUM_DOM | Registered CSR read data |
| sExtIrq | output | 1 | Supervisor external interrupt of the current domain |
| sSwIrq | output | 1 | Supervisor software interrupt of the current domain |
| mExtIrq | output | 1 | Machine interrupt: any enabled external pending |
| mSwIrq | output | 1 | Machine interrupt: any enabled software pending |
| ifAccEn | input | 1 | Indirect interrupt-file access request |
| ifAccKind | input | 2 | Access kind: 0 select, 1 data, 2 top-interrupt claim |
| ifAccWr | input | 1 | Access is a write |
| ifAccWData | input | IF_DW | Access write data |
| ifStrobe | output | NUM_DOM | Per-file access strobe |
| ifKindOut | output | 2 | Access kind broadcast to files |
| ifWrOut | output | 1 | Write flag broadcast to files |
| ifWDataOut | output | IF_DW | Write data broadcast to files |
| ifRDataVec | input | NUM_DOM*IF_DW | Read data of all files, file i in slice i |
| ifRData | output | IF_DW | Read data of the current domain's file |

## Verification
A fixed pending pattern 0x5A with all enables set is swept across every domain. This shows whether sExtIrq takes the current domain's own bit rather than a neighbour's. Partial enable masks with the pending bits placed only in masked domains separate the per-domain gating from the machine summary. Writes to the read-only pending addresses, followed by reads of every address, show that the write-ignore and the registered read timing are correct. Domain switches made while a claim access is active, followed by a long random mix of all inputs, show whether a strobe lands on a stale file. They also show whether the domain switch takes effect one cycle after the write.

// File: rtl/sdir_pkg.sv
package sdir_pkg;

  typedef enum logic [1:0] {
    CSR_EXT_PEND = 2'd0,
    CSR_EXT_EN   = 2'd1,
    CSR_SW_PEND  = 2'd2,
    CSR_SW_EN    = 2'd3
  } csrSel_e;

  typedef enum logic [1:0] {
    ACC_SELECT = 2'd0,
    ACC_DATA   = 2'd1,
    ACC_CLAIM  = 2'd2
  } accKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic extEnWr;
    logic swEnWr;
    logic domWr;
    logic rdCapture;
    logic accValid;
  } ctrlStrb_t;

endpackage

// File: rtl/sdir_ctrl.sv
module sdir_ctrl
  import sdir_pkg::*;
(
  input  logic      csrWrEn,
  input  logic      csrRdEn,
  input  logic [1:0] csrAddr,
  input  logic      domIdWrEn,
  input  logic      ifAccEn,
  output ctrlStrb_t strb
);

  always_comb begin
    strb           = '0;
    // pending words are read-only: writes to them are dropped here
    strb.extEnWr   = csrWrEn && (csrAddr == CSR_EXT_EN);
    strb.swEnWr    = csrWrEn && (csrAddr == CSR_SW_EN);
    strb.domWr     = domIdWrEn;
    strb.rdCapture = csrRdEn;
    strb.accValid  = ifAccEn;
  end

endmodule

// File: rtl/sdir_datapath.sv
module sdir_datapath
  import sdir_pkg::*;
#(
  parameter int NUM_DOM = 8,
  parameter int ID_W    = 3,
  parameter int IF_DW   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  input  logic [NUM_DOM-1:0]       extLines,
  input  logic [NUM_DOM-1:0]       swLines,
  input  logic [ID_W-1:0]          domIdWrData,
  input  logic [1:0]               csrAddr,
  input  logic [NUM_DOM-1:0]       csrWrData,
  output logic [NUM_DOM-1:0]       csrRdData,
  output logic                     sExtIrq,
  output logic                     sSwIrq,
  output logic                     mExtIrq,
  output logic                     mSwIrq,
  output logic [NUM_DOM-1:0]       ifStrobe,
  input  logic [NUM_DOM*IF_DW-1:0] ifRDataVec,
  output logic [IF_DW-1:0]         ifRData,
  output logic [ID_W-1:0]          domIdQ,
  output logic [NUM_DOM-1:0]       extEnQ
);

  logic [NUM_DOM-1:0] swEnQ;
  logic [NUM_DOM-1:0] domHot;
  logic [NUM_DOM-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extEnQ    <= '0;
      swEnQ     <= '0;
      domIdQ    <= '0;
      csrRdData <= '0;
    end else begin
      if (strb.extEnWr)   extEnQ    <= csrWrData;
      if (strb.swEnWr)    swEnQ     <= csrWrData;
      if (strb.domWr)     domIdQ    <= domIdWrData;
      if (strb.rdCapture) csrRdData <= rdNext;
    end
  end

  always_comb begin
    unique case (csrAddr)
      CSR_EXT_PEND: rdNext = extLines;
      CSR_EXT_EN:   rdNext = extEnQ;
      CSR_SW_PEND:  rdNext = swLines;
      default:      rdNext = swEnQ;
    endcase
  end

  // one-hot decode of the registered domain; ids beyond NUM_DOM match nothing
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign domHot[d] = (domIdQ == ID_W'(d));
  end

  assign sExtIrq  = |(extLines & extEnQ & domHot);
  assign sSwIrq   = |(swLines & swEnQ & domHot);
  assign mExtIrq  = |(extLines & extEnQ);
  assign mSwIrq   = |(swLines & swEnQ);
  assign ifStrobe = domHot & {NUM_DOM{strb.accValid}};

  always_comb begin
    ifRData = '0;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (domHot[d]) ifRData = ifRData | ifRDataVec[d*IF_DW +: IF_DW];
    end
  end

endmodule

// File: rtl/sd_irq_router.sv
module sd_irq_router
  import sdir_pkg::*;
#(
  parameter int NUM_DOM = 8,
  parameter int ID_W    = 3,
  parameter int IF_DW   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_DOM-1:0]       extLines,
  input  logic [NUM_DOM-1:0]       swLines,
  input  logic                     domIdWrEn,
  input  logic [ID_W-1:0]          domIdWrData,
  input  logic                     csrWrEn,
  input  logic                     csrRdEn,
  input  logic [1:0]               csrAddr,
  input  logic [NUM_DOM-1:0]       csrWrData,
  output logic [NUM_DOM-1:0]       csrRdData,
  output logic                     sExtIrq,
  output logic                     sSwIrq,
  output logic                     mExtIrq,
  output logic                     mSwIrq,
  input  logic                     ifAccEn,
  input  logic [1:0]               ifAccKind,
  input  logic                     ifAccWr,
  input  logic [IF_DW-1:0]         ifAccWData,
  output logic [NUM_DOM-1:0]       ifStrobe,
  output logic [1:0]               ifKindOut,
  output logic                     ifWrOut,
  output logic [IF_DW-1:0]         ifWDataOut,
  input  logic [NUM_DOM*IF_DW-1:0] ifRDataVec,
  output logic [IF_DW-1:0]         ifRData
);

  ctrlStrb_t          strb;
  logic [ID_W-1:0]    domIdQ;
  logic [NUM_DOM-1:0] extEnQ;

  sdir_ctrl u_ctrl (
    .csrWrEn   (csrWrEn),
    .csrRdEn   (csrRdEn),
    .csrAddr   (csrAddr),
    .domIdWrEn (domIdWrEn),
    .ifAccEn   (ifAccEn),
    .strb      (strb)
  );

  sdir_datapath #(
    .NUM_DOM (NUM_DOM),
    .ID_W    (ID_W),
    .IF_DW   (IF_DW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .extLines    (extLines),
    .swLines     (swLines),
    .domIdWrData (domIdWrData),
    .csrAddr     (csrAddr),
    .csrWrData   (csrWrData),
    .csrRdData   (csrRdData),
    .sExtIrq     (sExtIrq),
    .sSwIrq      (sSwIrq),
    .mExtIrq     (mExtIrq),
    .mSwIrq      (mSwIrq),
    .ifStrobe    (ifStrobe),
    .ifRDataVec  (ifRDataVec),
    .ifRData     (ifRData),
    .domIdQ      (domIdQ),
    .extEnQ      (extEnQ)
  );

  // access attributes go to every file; only the strobe is steered
  assign ifKindOut  = ifAccKind;
  assign ifWrOut    = ifAccWr;
  assign ifWDataOut = ifAccWData;

endmodule

// File: rtl/sdir_chk.sv
module sdir_chk #(
  parameter int NUM_DOM = 8,
  parameter int ID_W    = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               csrWrEn,
  input logic               csrRdEn,
  input logic [1:0]         csrAddr,
  input logic [NUM_DOM-1:0] csrWrData,
  input logic [NUM_DOM-1:0] csrRdData,
  input logic [NUM_DOM-1:0] extLines,
  input logic               domIdWrEn,
  input logic [ID_W-1:0]    domIdWrData,
  input logic [ID_W-1:0]    domIdQ,
  input logic [NUM_DOM-1:0] extEnQ,
  input logic               sExtIrq,
  input logic               mExtIrq,
  input logic               sSwIrq,
  input logic               mSwIrq,
  input logic               ifAccEn,
  input logic [NUM_DOM-1:0] ifStrobe
);

  p_rd_pend_r1: assert property (@(posedge clk) disable iff (!rstN)
    (csrRdEn && csrAddr == 2'd0) |=> csrRdData == $past(extLines));

  p_en_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrAddr == 2'd1) |=> extEnQ == $past(csrWrData));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !csrRdEn |=> $stable(csrRdData));

  p_dom_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    domIdWrEn |=> domIdQ == $past(domIdWrData));

  p_ext_summary_r5: assert property (@(posedge clk) disable iff (!rstN)
    sExtIrq |-> mExtIrq);

  p_sw_summary_r6: assert property (@(posedge clk) disable iff (!rstN)
    sSwIrq |-> mSwIrq);

  p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ifStrobe));

  p_strobe_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ifAccEn |-> ifStrobe == '0);

endmodule

bind sd_irq_router sdir_chk #(.NUM_DOM(NUM_DOM), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .csrWrEn     (csrWrEn),
  .csrRdEn     (csrRdEn),
  .csrAddr     (csrAddr),
  .csrWrData   (csrWrData),
  .csrRdData   (csrRdData),
  .extLines    (extLines),
  .domIdWrEn   (domIdWrEn),
  .domIdWrData (domIdWrData),
  .domIdQ      (domIdQ),
  .extEnQ      (extEnQ),
  .sExtIrq     (sExtIrq),
  .mExtIrq     (mExtIrq),
  .sSwIrq      (sSwIrq),
  .mSwIrq      (mSwIrq),
  .ifAccEn     (ifAccEn),
  .ifStrobe    (ifStrobe)
);

// File: tb/sd_irq_router_tb.sv
`timescale 1ns/1ps
module sd_irq_router_tb;

  localparam int N  = 8;
  localparam int IW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]    extLines = '0, swLines = '0, csrWrData = '0;
  logic            domIdWrEn = 0, csrWrEn = 0, csrRdEn = 0, ifAccEn = 0, ifAccWr = 0;
  logic [IW-1:0]   domIdWrData = '0;
  logic [1:0]      csrAddr = '0, ifAccKind = '0;
  logic [DW-1:0]   ifAccWData = '0;
  logic [N*DW-1:0] ifRDataVec;
  logic [N-1:0]    csrRdData, ifStrobe;
  logic            sExtIrq, sSwIrq, mExtIrq, mSwIrq, ifWrOut;
  logic [1:0]      ifKindOut;
  logic [DW-1:0]   ifWDataOut, ifRData;

  sd_irq_router #(.NUM_DOM(N), .ID_W(IW), .IF_DW(DW)) u_dut (.*);

  // pending stimulus, copied to the DUT at the falling edge
  logic [N-1:0]  nExt = '0, nSw = '0, nWd = '0;
  logic          nDomWr = 0, nWr = 0, nRd = 0, nAcc = 0, nAccWr = 0;
  logic [IW-1:0] nDom = '0;
  logic [1:0]    nAddr = '0, nKind = '0;
  logic [DW-1:0] nAccWd = '0;

  // reference model state
  int unsigned mDom;
  bit [N-1:0]  mExtEn, mSwEn, mRd;

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic bit lineOf(input bit [N-1:0] v, input int unsigned d);
    return (d < N) ? v[d] : 1'b0;
  endfunction

  task automatic compareAll();
    bit [N-1:0] expStrobe;
    bit [DW-1:0] expRd;
    expStrobe = (nAcc && mDom < N) ? (N'(1) << mDom) : '0;
    expRd     = (mDom < N) ? DW'(ifRDataVec >> (mDom*DW)) : '0;
    chk("R3,R4", "sExtIrq", sExtIrq, lineOf(extLines & mExtEn, mDom));
    chk("R5", "mExtIrq", mExtIrq, |(extLines & mExtEn));
    chk("R6", "sSwIrq", sSwIrq, lineOf(swLines & mSwEn, mDom));
    chk("R6", "mSwIrq", mSwIrq, |(swLines & mSwEn));
    chk((nAcc && nKind == 2'd2) ? "R8" : "R7", "ifStrobe", ifStrobe, expStrobe);
    chk("R8", "ifRData", ifRData, expRd);
    chk("R7", "ifKindOut", ifKindOut, ifAccKind);
    chk("R7", "ifWrOut", ifWrOut, ifAccWr);
    chk("R7", "ifWDataOut", ifWDataOut, ifAccWData);
    chk("R1,R2", "csrRdData", csrRdData, mRd);
  endtask

  task automatic cycle();
    @(negedge clk);
    extLines = nExt; swLines = nSw; csrWrData = nWd; domIdWrEn = nDomWr;
    domIdWrData = nDom; csrWrEn = nWr; csrRdEn = nRd; csrAddr = nAddr;
    ifAccEn = nAcc; ifAccKind = nKind; ifAccWr = nAccWr; ifAccWData = nAccWd;
    #1;
    compareAll();
    @(posedge clk);
    if (nRd) begin
      case (nAddr)
        2'd0: mRd = nExt;
        2'd1: mRd = mExtEn;
        2'd2: mRd = nSw;
        default: mRd = mSwEn;
      endcase
    end
    if (nWr && nAddr == 2'd1) mExtEn = nWd;
    if (nWr && nAddr == 2'd3) mSwEn = nWd;
    if (nDomWr) mDom = nDom;
  endtask

  task automatic idle();
    nDomWr = 0; nWr = 0; nRd = 0; nAcc = 0;
  endtask

  task automatic csrWrite(input int a, input bit [N-1:0] v);
    idle(); nWr = 1; nAddr = 2'(a); nWd = v; cycle(); idle();
  endtask

  task automatic csrRead(input int a);
    idle(); nRd = 1; nAddr = 2'(a); cycle(); idle(); cycle();
  endtask

  task automatic setDom(input int d);
    idle(); nDomWr = 1; nDom = IW'(d); cycle(); idle();
  endtask

  initial begin
    for (int i = 0; i < N; i++) ifRDataVec[i*DW +: DW] = DW'(16'h1000 + i * 16'h0123);
    mDom = 0; mExtEn = '0; mSwEn = '0; mRd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // reset state: all outputs quiet even with lines raised (R2, R4, R5)
    nExt = '1; nSw = '1; cycle(); cycle();
    csrRead(1); csrRead(3);

    // R4: sweep the current domain with pattern 0x5A, all enabled
    csrWrite(1, '1); csrWrite(3, '1);
    nExt = 8'h5A; nSw = 8'hA5;
    for (int d = 0; d < N; d++) begin setDom(d); cycle(); end

    // R5: pending only in masked domains
    csrWrite(1, 8'h0F); nExt = 8'hF0; cycle();
    nExt = 8'h18; cycle();
    csrWrite(3, 8'h01); nSw = 8'hFE; cycle();

    // R1, R6: writes to read-only pending words change nothing
    csrWrite(0, 8'h00); csrWrite(2, 8'h00);
    csrRead(0); csrRead(1); csrRead(2); csrRead(3);
    // R2: read and write together return the old value
    idle(); nWr = 1; nRd = 1; nAddr = 2'd1; nWd = 8'h3C; cycle(); idle(); cycle();
    csrRead(1);

    // R3, R8: claim accesses around domain switches
    for (int d = 0; d < N; d++) begin
      idle(); nAcc = 1; nKind = 2'd2; nDomWr = 1; nDom = IW'(N - 1 - d); cycle();
      idle(); nAcc = 1; nKind = 2'd2; cycle();
      nAcc = 1; nKind = 2'd1; nAccWr = 1; nAccWd = DW'(16'hBEE0 + d); cycle();
    end

    // random mix
    for (int k = 0; k < 600; k++) begin
      nExt = N'($urandom); nSw = N'($urandom); nWd = N'($urandom);
      nDomWr = ($urandom % 4) == 0; nDom = IW'($urandom);
      nWr = ($urandom % 5) == 0; nRd = ($urandom % 3) == 0; nAddr = 2'($urandom);
      nAcc = ($urandom % 2) == 0; nKind = 2'($urandom % 3);
      nAccWr = 1'($urandom); nAccWd = DW'($urandom);
      cycle();
    end
    idle(); cycle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule